// File: doc/BRIEF.md
# Exception Entry Sequencer

This block carries out the state save and vector redirect that a 32-bit processor with 16-bit instructions performs when it enters an exception or interrupt handler. The core presents its current program counter, status word, stack register (R15) and vector base, together with a cause: an interrupt event code, an exception event code and a flag marking a trap instruction. One clock after the cause is accepted, the block presents all the values the core must commit, each with its own write strobe: saved PC, saved status, saved stack pointer, one event-code register, the new status word and the new PC.

The cause arrives on a valid/ready handshake. `trig_ready` is high whenever the block is idle. It drops for exactly one cycle, the cycle in which a result or a fault is presented. A cause held on `trig_valid` while `trig_ready` is low is not taken, and the core must keep it stable until the next cycle with ready high. Each accepted cause produces exactly one response cycle, so one entry can be taken every two cycles. The state inputs are sampled in the accepting cycle.

If the status word already has its block bit set when a cause is accepted, the entry is refused. No register is written, and a double-fault pulse is raised instead of the done pulse.

Top module: `exc_entry_seq`

## Requirements
- R1: In the cycle after a cause is accepted (`trig_valid` and `trig_ready` both high at a clock edge) with status bit 28 clear, `done`, `spc_we`, `ssr_we`, `sgr_we`, `sr_we` and `pc_we` are high for exactly that one cycle. In that cycle `ssr_val` equals the sampled status word and `sgr_val` equals the sampled R15.
- R2: When the accepted interrupt code is nonzero, `intevt_we` is high with `intevt_val` equal to that code, and `expevt_we` stays low.
- R3: When the accepted interrupt code is zero, `expevt_we` is high with `expevt_val` equal to the exception code, and `intevt_we` stays low.
- R4: `sr_val` equals the sampled status word with bits 30 (privileged mode), 29 (register bank) and 28 (block) set, and every other bit unchanged.
- R5: `pc_val` equals the sampled vector base plus 0x100.
- R6: `spc_val` equals the sampled PC plus 2 when the trap flag is set and the interrupt code is zero. Otherwise it equals the sampled PC, which means the trap flag has no effect on an interrupt.
- R7: If status bit 28 is set when a cause is accepted, the next cycle shows `dbl_fault` high for one cycle. In that cycle `done` and all write strobes stay low.
- R8: `trig_ready` is low in exactly the cycles in which `done` or `dbl_fault` is high, and high otherwise. A cause offered while ready is low is not taken and produces no response in the following cycle.
- R9: During and right after reset, all strobes, `done` and `dbl_fault` are low and `trig_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_valid | input | 1 | Cause offered |
| trig_ready | output | 1 | Block can take a cause |
| trig_intcode | input | 12 | Interrupt event code, zero for an exception |
| trig_expcode | input | 12 | Exception event code |
| trig_is_trap | input | 1 | Cause is a trap instruction |
| cur_pc | input | 32 | Current PC |
| cur_sr | input | 32 | Current status word |
| cur_r15 | input | 32 | Current R15 |
| cur_vbr | input | 32 | Vector base |
| spc_we | output | 1 | Saved-PC write strobe |
| spc_val | output | 32 | Saved-PC value |
| ssr_we | output | 1 | Saved-status write strobe |
| ssr_val | output | 32 | Saved-status value |
| sgr_we | output | 1 | Saved-R15 write strobe |
| sgr_val | output | 32 | Saved-R15 value |
| expevt_we | output | 1 | Exception-code write strobe |
| expevt_val | output | 12 | Exception-code value |
| intevt_we | output | 1 | Interrupt-code write strobe |
| intevt_val | output | 12 | Interrupt-code value |
| sr_we | output | 1 | Status write strobe |
| sr_val | output | 32 | New status word |
| pc_we | output | 1 | PC write strobe |
| pc_val | output | 32 | New PC |
| done | output | 1 | Entry completed |
| dbl_fault | output | 1 | Entry refused, block bit was already set |

## Verification
The hardest case to reach is a cause offered during the single busy cycle, because a normal requester drops valid before that cycle. A directed sequence keeps `trig_valid` high straight through the response cycle and changes the cause data. It then checks that no second response appears in the following cycle, and that the new data, not the old, is committed one cycle later. The random stimulus sets the block bit in about a quarter of the entries and gives the interrupt code a zero value about half the time. Trap flags appear on both interrupts and exceptions, and fixed cases cover a PC that wraps when 2 is added and a vector base that carries when 0x100 is added.

// File: rtl/exc_pkg.sv
package exc_pkg;
  parameter int XLEN = 32;
  parameter int EVW  = 12;
  parameter int BIT_MD = 30;
  parameter int BIT_RB = 29;
  parameter int BIT_BL = 28;
  parameter int INSN_BYTES = 2;
  parameter int VEC_OFS = 32'h100;

  typedef struct packed {
    logic [XLEN-1:0] spc;
    logic [XLEN-1:0] ssr;
    logic [XLEN-1:0] sgr;
    logic [XLEN-1:0] sr;
    logic [XLEN-1:0] pc;
    logic [EVW-1:0]  code;
    logic            is_int;
  } entry_t;
endpackage

// File: rtl/exc_cause_decode.sv
module exc_cause_decode #(
  parameter int EVW = exc_pkg::EVW
) (
  input  logic [EVW-1:0] intcode,
  input  logic [EVW-1:0] expcode,
  input  logic           is_trap,
  input  logic           sr_bl,
  output logic           is_int,
  output logic [EVW-1:0] code,
  output logic           trap_adj,
  output logic           blocked
);
  always_comb begin
    is_int   = |intcode;
    code     = is_int ? intcode : expcode;
    trap_adj = is_trap && !is_int;
    blocked  = sr_bl;
  end
endmodule

// File: rtl/exc_state_calc.sv
module exc_state_calc
  import exc_pkg::*;
#(
  parameter int W = exc_pkg::XLEN
) (
  input  logic [W-1:0] pc,
  input  logic [W-1:0] sr,
  input  logic [W-1:0] r15,
  input  logic [W-1:0] vbr,
  input  logic         trap_adj,
  output logic [W-1:0] spc,
  output logic [W-1:0] ssr,
  output logic [W-1:0] sgr,
  output logic [W-1:0] new_sr,
  output logic [W-1:0] new_pc
);
  localparam logic [W-1:0] STEP = W'(INSN_BYTES);
  localparam logic [W-1:0] OFS  = W'(VEC_OFS);
  localparam logic [W-1:0] SET_MASK =
    (W'(1) << BIT_MD) | (W'(1) << BIT_RB) | (W'(1) << BIT_BL);

  always_comb begin
    spc    = trap_adj ? pc + STEP : pc;
    ssr    = sr;
    sgr    = r15;
    new_sr = sr | SET_MASK;
    new_pc = vbr + OFS;
  end
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            trig_valid,
  output logic            trig_ready,
  input  logic [EVW-1:0]  trig_intcode,
  input  logic [EVW-1:0]  trig_expcode,
  input  logic            trig_is_trap,
  input  logic [XLEN-1:0] cur_pc,
  input  logic [XLEN-1:0] cur_sr,
  input  logic [XLEN-1:0] cur_r15,
  input  logic [XLEN-1:0] cur_vbr,
  output logic            spc_we,
  output logic [XLEN-1:0] spc_val,
  output logic            ssr_we,
  output logic [XLEN-1:0] ssr_val,
  output logic            sgr_we,
  output logic [XLEN-1:0] sgr_val,
  output logic            expevt_we,
  output logic [EVW-1:0]  expevt_val,
  output logic            intevt_we,
  output logic [EVW-1:0]  intevt_val,
  output logic            sr_we,
  output logic [XLEN-1:0] sr_val,
  output logic            pc_we,
  output logic [XLEN-1:0] pc_val,
  output logic            done,
  output logic            dbl_fault
);
  logic           is_int, trap_adj, blocked, accept;
  logic [EVW-1:0] code;
  entry_t         nxt, held;
  logic           resp_q, fault_q;

  exc_cause_decode #(.EVW(EVW)) u_dec (
    .intcode (trig_intcode),
    .expcode (trig_expcode),
    .is_trap (trig_is_trap),
    .sr_bl   (cur_sr[BIT_BL]),
    .is_int  (is_int),
    .code    (code),
    .trap_adj(trap_adj),
    .blocked (blocked)
  );

  exc_state_calc #(.W(XLEN)) u_calc (
    .pc      (cur_pc),
    .sr      (cur_sr),
    .r15     (cur_r15),
    .vbr     (cur_vbr),
    .trap_adj(trap_adj),
    .spc     (nxt.spc),
    .ssr     (nxt.ssr),
    .sgr     (nxt.sgr),
    .new_sr  (nxt.sr),
    .new_pc  (nxt.pc)
  );

  assign nxt.code   = code;
  assign nxt.is_int = is_int;

  assign trig_ready = !(resp_q || fault_q);
  assign accept     = trig_valid && trig_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_q  <= 1'b0;
      fault_q <= 1'b0;
      held    <= '0;
    end else begin
      resp_q  <= accept && !blocked;
      fault_q <= accept && blocked;
      if (accept && !blocked) held <= nxt;
    end
  end

  assign spc_we     = resp_q;
  assign ssr_we     = resp_q;
  assign sgr_we     = resp_q;
  assign sr_we      = resp_q;
  assign pc_we      = resp_q;
  assign expevt_we  = resp_q && !held.is_int;
  assign intevt_we  = resp_q && held.is_int;
  assign done       = resp_q;
  assign dbl_fault  = fault_q;
  assign spc_val    = held.spc;
  assign ssr_val    = held.ssr;
  assign sgr_val    = held.sgr;
  assign sr_val     = held.sr;
  assign pc_val     = held.pc;
  assign expevt_val = held.code;
  assign intevt_val = held.code;
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk
  import exc_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            trig_valid,
  input logic            trig_ready,
  input logic [XLEN-1:0] cur_sr,
  input logic [XLEN-1:0] cur_vbr,
  input logic            spc_we,
  input logic            ssr_we,
  input logic            sgr_we,
  input logic            expevt_we,
  input logic            intevt_we,
  input logic            sr_we,
  input logic [XLEN-1:0] sr_val,
  input logic            pc_we,
  input logic [XLEN-1:0] pc_val,
  input logic            done,
  input logic            dbl_fault
);
  logic acc;
  assign acc = trig_valid && trig_ready;

  AST_DONE_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (spc_we && ssr_we && sgr_we && sr_we && pc_we)); // R1
  AST_ONE_EVENT_REG: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (expevt_we != intevt_we)); // R2
  AST_NO_EVENT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> !(expevt_we || intevt_we)); // R3
  AST_SR_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !cur_sr[BIT_BL]) |=> (sr_we && sr_val[BIT_MD] && sr_val[BIT_RB] && sr_val[BIT_BL])); // R4
  AST_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !cur_sr[BIT_BL]) |=> (pc_we && pc_val == $past(cur_vbr) + XLEN'(VEC_OFS))); // R5
  AST_FAULT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cur_sr[BIT_BL]) |=> (dbl_fault && !done && !pc_we && !spc_we)); // R7
  AST_BUSY_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (done || dbl_fault) |-> !trig_ready); // R8
  AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> !(done || dbl_fault)); // R8
  AST_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, dbl_fault})); // R7
endmodule

bind exc_entry_seq exc_entry_chk u_chk (
  .clk(clk), .rst_n(rst_n), .trig_valid(trig_valid), .trig_ready(trig_ready),
  .cur_sr(cur_sr), .cur_vbr(cur_vbr), .spc_we(spc_we), .ssr_we(ssr_we),
  .sgr_we(sgr_we), .expevt_we(expevt_we), .intevt_we(intevt_we),
  .sr_we(sr_we), .sr_val(sr_val), .pc_we(pc_we), .pc_val(pc_val),
  .done(done), .dbl_fault(dbl_fault)
);

// File: tb/tb_exc_entry_seq.sv
`timescale 1ns/1ps
module tb_exc_entry_seq;
  logic clk = 1'b0, rst_n = 1'b0;
  logic trig_valid = 1'b0, trig_is_trap = 1'b0;
  logic [11:0] trig_intcode = '0, trig_expcode = '0;
  logic [31:0] cur_pc = '0, cur_sr = '0, cur_r15 = '0, cur_vbr = '0;
  logic trig_ready, spc_we, ssr_we, sgr_we, expevt_we, intevt_we, sr_we, pc_we, done, dbl_fault;
  logic [31:0] spc_val, ssr_val, sgr_val, sr_val, pc_val;
  logic [11:0] expevt_val, intevt_val;
  int n_tests = 0, n_fail = 0;

  always #2 clk = ~clk;

  exc_entry_seq dut (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp_v);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp_v);
    end
  endtask

  function automatic logic [31:0] f_sr(input logic [31:0] sr);
    return sr | 32'h7000_0000;
  endfunction
  function automatic logic [31:0] f_spc(input logic [31:0] pc, input logic [11:0] ic, input bit tr);
    return (tr && ic == 0) ? pc + 32'd2 : pc;
  endfunction

  task automatic drive(input logic [11:0] ic, input logic [11:0] ec, input bit tr,
                       input logic [31:0] pc, input logic [31:0] sr,
                       input logic [31:0] r15, input logic [31:0] vbr);
    trig_intcode = ic; trig_expcode = ec; trig_is_trap = tr;
    cur_pc = pc; cur_sr = sr; cur_r15 = r15; cur_vbr = vbr;
    trig_valid = 1'b1;
  endtask

  task automatic check_resp(input logic [11:0] ic, input logic [11:0] ec, input bit tr,
                            input logic [31:0] pc, input logic [31:0] sr,
                            input logic [31:0] r15, input logic [31:0] vbr);
    if (sr[28]) begin
      chk(dbl_fault && !done && !spc_we && !pc_we && !sr_we && !expevt_we && !intevt_we,
          "R7 fault", {done, spc_we, pc_we, dbl_fault}, 32'h1);
      chk(!trig_ready, "R8 busy on fault", trig_ready, 0);
    end else begin
      chk(done && spc_we && ssr_we && sgr_we && sr_we && pc_we && !dbl_fault,
          "R1 strobes", {done, spc_we, ssr_we, sgr_we, sr_we, pc_we, dbl_fault}, 32'h7e);
      chk(ssr_val == sr && sgr_val == r15, "R1 ssr/sgr", ssr_val ^ sgr_val, sr ^ r15);
      if (ic != 0)
        chk(intevt_we && !expevt_we && intevt_val == ic, "R2 intevt",
            {intevt_we, expevt_we, 2'b0, intevt_val}, {4'h8, ic});
      else
        chk(expevt_we && !intevt_we && expevt_val == ec, "R3 expevt",
            {expevt_we, intevt_we, 2'b0, expevt_val}, {4'h8, ec});
      chk(sr_val == f_sr(sr), "R4 new sr", sr_val, f_sr(sr));
      chk(pc_val == vbr + 32'h100, "R5 vector", pc_val, vbr + 32'h100);
      chk(spc_val == f_spc(pc, ic, tr), "R6 spc", spc_val, f_spc(pc, ic, tr));
      chk(!trig_ready, "R8 busy", trig_ready, 0);
    end
  endtask

  task automatic entry(input logic [11:0] ic, input logic [11:0] ec, input bit tr,
                       input logic [31:0] pc, input logic [31:0] sr,
                       input logic [31:0] r15, input logic [31:0] vbr);
    @(negedge clk);
    drive(ic, ec, tr, pc, sr, r15, vbr);
    @(negedge clk);
    trig_valid = 1'b0;
    check_resp(ic, ec, tr, pc, sr, r15, vbr);
    @(negedge clk);
    chk(trig_ready && !done && !dbl_fault && !spc_we, "R1 single pulse / R8 ready",
        {trig_ready, done, dbl_fault}, 32'h4);
  endtask

  initial begin : watchdog
    #400000;
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h0000_5EED));
    repeat (3) @(negedge clk);
    chk(trig_ready && !done && !dbl_fault && !spc_we && !pc_we && !expevt_we && !intevt_we,
        "R9 in reset", {trig_ready, done, dbl_fault}, 32'h4);
    rst_n = 1'b1;
    @(negedge clk);
    chk(trig_ready && !done && !dbl_fault, "R9 after reset", {trig_ready, done, dbl_fault}, 32'h4);

    // directed corners
    entry(12'h000, 12'h160, 1'b1, 32'hFFFF_FFFE, 32'h0000_00F0, 32'h1234, 32'h8000_0000); // R6 wrap
    entry(12'h3E0, 12'h160, 1'b1, 32'h0000_1000, 32'h0000_0001, 32'h55, 32'hFFFF_FF80);   // R6 trap ignored, R5 carry
    entry(12'h000, 12'h040, 1'b0, 32'h0C00_0010, 32'h4000_0000, 32'h77, 32'h0);           // R3
    entry(12'h200, 12'h0, 1'b0, 32'h0C00_0020, 32'h1000_0000, 32'h88, 32'h1000);           // R7
    entry(12'h600, 12'h0, 1'b0, 32'h0C00_0030, 32'hAFFF_FFFF, 32'h99, 32'h2000);           // R4

    // R8: valid held through the busy cycle with new data
    @(negedge clk);
    drive(12'h000, 12'h0E0, 1'b0, 32'h100, 32'h0, 32'h1, 32'h4000);
    @(negedge clk);
    check_resp(12'h000, 12'h0E0, 1'b0, 32'h100, 32'h0, 32'h1, 32'h4000);
    drive(12'h420, 12'h0, 1'b0, 32'h300, 32'h5, 32'h2, 32'h6000);
    @(negedge clk);
    chk(!done && !dbl_fault && trig_ready, "R8 no take while busy", {done, dbl_fault, trig_ready}, 32'h1);
    @(negedge clk);
    trig_valid = 1'b0;
    check_resp(12'h420, 12'h0, 1'b0, 32'h300, 32'h5, 32'h2, 32'h6000);
    @(negedge clk);

    // random
    for (int i = 0; i < 400; i++) begin
      logic [11:0] ic, ec;
      logic [31:0] pc, sr, r15, vbr;
      bit tr;
      ic  = ($urandom % 2) ? 12'($urandom) : 12'h0;
      ec  = 12'($urandom);
      tr  = 1'($urandom);
      pc  = $urandom & 32'hFFFF_FFFE;
      sr  = $urandom & 32'h8FFF_FFFF;
      if ($urandom % 4 == 0) sr[28] = 1'b1;
      r15 = $urandom;
      vbr = $urandom;
      entry(ic, ec, tr, pc, sr, r15, vbr);
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule